// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block is the chip-level reset controller. It takes five kinds of request: a power-on detect, a brown-out detect, an external reset pin, a watchdog time-out and a sleep indication from the core. From these it drives one chip reset output. That output is held by a latch. Any qualifying event sets the latch, and the latch is released only after two start-up delays have finished.

The first delay is a power-up delay. It counts rising edges of a slow internal oscillator tick. The second is an oscillator start-up delay. It counts rising edges of the external oscillator tick, and it starts only once the power-up delay is complete. Each delay has its own enable strap. A disabled delay is treated as already finished.

A watchdog time-out while the core is asleep does not reset the chip. It produces a one-cycle wake pulse instead. The block also records two status flags and a cause code, so that software can tell the kind of reset apart from a wake-up.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_det` is high, and afterwards until another event occurs, `chip_rst`=1, `flag_timeout`=1, `flag_pwrdn`=1 and `cause`=0 (power-on).
- R2: `ext_rst` with `sleep_st`=0 sets `chip_rst` on the next edge, sets `flag_timeout`=1, leaves `flag_pwrdn` unchanged and sets `cause`=1.
- R3: `ext_rst` with `sleep_st`=1 sets `chip_rst`, sets `flag_timeout`=1, leaves `flag_pwrdn` unchanged and sets `cause`=2.
- R4: `wdt_to` with `sleep_st`=0 sets `chip_rst`, clears `flag_timeout`, leaves `flag_pwrdn` unchanged and sets `cause`=3.
- R5: `wdt_to` with `sleep_st`=1 leaves `chip_rst` low. It pulses `wake` high for exactly one cycle, clears `flag_timeout`, leaves `flag_pwrdn` unchanged and sets `cause`=4.
- R6: `brown_det` with `brown_en`=1 sets `chip_rst` and sets both flags to 1 with `cause`=5. With `brown_en`=0, `brown_det` has no effect on any output.
- R7: A rising edge of `sleep_st` clears `flag_pwrdn` on the next clock edge.
- R8: `chip_rst` falls only after two counts have completed in order: 2^PWRUP_W rising edges of `lfosc_tick`, followed by 2^OSCST_W rising edges of `xosc_tick`. External oscillator edges that arrive before the power-up count completes are not counted.
- R9: When `pwrup_en`=0 or `oscst_en`=0, the corresponding delay counts as complete. With both disabled, a one-cycle event holds `chip_rst` high for exactly one cycle.
- R10: Any reset event during a countdown restarts both delay counts from zero.
- R11: When events coincide, the cause and flags follow the priority brown-out (enabled), then external pin, then watchdog.
- R12: Both tick inputs pass through two-flop synchronizers. Only their rising edges advance a count, so a tick held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_det | input | 1 | Power-on detect, asynchronous, active high |
| brown_det | input | 1 | Brown-out detect, active high |
| brown_en | input | 1 | Brown-out reset enable strap |
| ext_rst | input | 1 | External reset pin request, active high |
| wdt_to | input | 1 | Watchdog time-out pulse |
| sleep_st | input | 1 | Core is in sleep (level) |
| pwrup_en | input | 1 | Power-up delay enable |
| oscst_en | input | 1 | Oscillator start-up delay enable |
| lfosc_tick | input | 1 | Slow internal oscillator, asynchronous |
| xosc_tick | input | 1 | External oscillator, asynchronous |
| chip_rst | output | 1 | Chip reset, active high |
| wake | output | 1 | One-cycle wake-up pulse |
| flag_timeout | output | 1 | Time-out status flag |
| flag_pwrdn | output | 1 | Power-down status flag |
| cause | output | 3 | Last recorded event code (0..5) |

## Verification
The bench builds the block with PWRUP_W=3 and OSCST_W=2, which gives 8 slow ticks and 4 external ticks. With these values the full release sequence, the ordering of the two delays and a restart in the middle of a count can each be reached in a few hundred cycles. A table walks every cause, including the brown-out enable and the coinciding-event priorities, with both delays disabled so that each reset lasts exactly one cycle. Directed cases then run each delay on its own and both in sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    CAUSE_POR       = 3'd0,
    CAUSE_EXT_RUN   = 3'd1,
    CAUSE_EXT_SLEEP = 3'd2,
    CAUSE_WDT_RUN   = 3'd3,
    CAUSE_WDT_WAKE  = 3'd4,
    CAUSE_BROWN     = 3'd5
  } cause_e;

  typedef struct packed {
    logic   valid;   // some event present this cycle
    logic   rst;     // event sets the reset latch
    logic   to_val;  // new time-out flag value
    logic   pd_set;  // event forces power-down flag high
    cause_e cause;
  } evt_t;

  // Priority: enabled brown-out, then pin, then watchdog.
  function automatic evt_t classify(input logic ext, input logic wdt,
                                    input logic brown, input logic sleep);
    evt_t e;
    e = '{valid: 1'b0, rst: 1'b0, to_val: 1'b1, pd_set: 1'b0, cause: CAUSE_POR};
    if (brown) begin
      e.valid = 1'b1; e.rst = 1'b1; e.to_val = 1'b1; e.pd_set = 1'b1;
      e.cause = CAUSE_BROWN;
    end else if (ext) begin
      e.valid = 1'b1; e.rst = 1'b1; e.to_val = 1'b1;
      e.cause = sleep ? CAUSE_EXT_SLEEP : CAUSE_EXT_RUN;
    end else if (wdt) begin
      e.valid = 1'b1; e.rst = ~sleep; e.to_val = 1'b0;
      e.cause = sleep ? CAUSE_WDT_WAKE : CAUSE_WDT_RUN;
    end
    return e;
  endfunction

  // Delay counter step: returns {done, count}.
  function automatic logic [32:0] count_step(input logic [31:0] cnt,
                                              input int unsigned w);
    logic [31:0] last;
    last = (32'd1 << w) - 32'd1;
    if (cnt == last) return {1'b1, 32'd0};
    return {1'b0, cnt + 32'd1};
  endfunction

endpackage

// File: rtl/rst_tick_sync.sv
module rst_tick_sync (
  input  logic clk,
  input  logic arst,
  input  logic raw,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/rst_delay_ctr.sv
module rst_delay_ctr import rst_seq_pkg::*; #(
  parameter int W = 11
) (
  input  logic clk,
  input  logic arst,
  input  logic clr,
  input  logic en,
  input  logic adv,
  output logic ok
);
  logic [W-1:0] cnt;
  logic         done;
  logic [32:0]  nxt;

  assign nxt = count_step(32'(cnt), W);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (en && adv && !done) begin
      cnt  <= nxt[W-1:0];
      done <= nxt[32];
    end
  end

  assign ok = ~en | done;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl import rst_seq_pkg::*; #(
  parameter int PWRUP_W = 11,
  parameter int OSCST_W = 10
) (
  input  logic       clk,
  input  logic       por_det,
  input  logic       brown_det,
  input  logic       brown_en,
  input  logic       ext_rst,
  input  logic       wdt_to,
  input  logic       sleep_st,
  input  logic       pwrup_en,
  input  logic       oscst_en,
  input  logic       lfosc_tick,
  input  logic       xosc_tick,
  output logic       chip_rst,
  output logic       wake,
  output logic       flag_timeout,
  output logic       flag_pwrdn,
  output logic [2:0] cause
);
  logic   lf_rise, xo_rise;
  logic   pwrup_ok, oscst_ok, oscst_adv;
  logic   brown_q, sleep_q, sleep_entry;
  evt_t   evt;
  cause_e cause_q;

  assign brown_q     = brown_det & brown_en;
  assign evt         = classify(ext_rst, wdt_to, brown_q, sleep_st);
  assign sleep_entry = sleep_st & ~sleep_q;
  assign oscst_adv   = xo_rise & pwrup_ok;   // cascade: second delay waits for first

  rst_tick_sync u_lf_sync (.clk(clk), .arst(por_det), .raw(lfosc_tick), .rise(lf_rise));
  rst_tick_sync u_xo_sync (.clk(clk), .arst(por_det), .raw(xosc_tick),  .rise(xo_rise));

  rst_delay_ctr #(.W(PWRUP_W)) u_pwrup (
    .clk(clk), .arst(por_det), .clr(evt.rst), .en(pwrup_en),
    .adv(lf_rise), .ok(pwrup_ok)
  );

  rst_delay_ctr #(.W(OSCST_W)) u_oscst (
    .clk(clk), .arst(por_det), .clr(evt.rst), .en(oscst_en),
    .adv(oscst_adv), .ok(oscst_ok)
  );

  always_ff @(posedge clk or posedge por_det) begin
    if (por_det) begin
      chip_rst     <= 1'b1;
      wake         <= 1'b0;
      flag_timeout <= 1'b1;
      flag_pwrdn   <= 1'b1;
      cause_q      <= CAUSE_POR;
      sleep_q      <= 1'b0;
    end else begin
      sleep_q <= sleep_st;
      wake    <= evt.valid & ~evt.rst;
      if (evt.valid) begin
        cause_q      <= evt.cause;
        flag_timeout <= evt.to_val;
      end
      if (evt.valid && evt.pd_set) flag_pwrdn <= 1'b1;
      else if (sleep_entry)        flag_pwrdn <= 1'b0;
      if (evt.rst)                                  chip_rst <= 1'b1;
      else if (chip_rst && pwrup_ok && oscst_ok)    chip_rst <= 1'b0;
    end
  end

  assign cause = cause_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk,
  input logic por_det,
  input logic brown_det,
  input logic brown_en,
  input logic ext_rst,
  input logic wdt_to,
  input logic sleep_st,
  input logic chip_rst,
  input logic wake,
  input logic flag_timeout,
  input logic flag_pwrdn,
  input logic pwrup_ok,
  input logic oscst_ok,
  input logic oscst_adv,
  input logic sleep_entry
);
  assert_evt_sets_rst_R2: assert property (@(posedge clk) disable iff (por_det)
    (ext_rst || (brown_det && brown_en) || (wdt_to && !sleep_st)) |=> chip_rst);

  assert_wdt_sleep_wakes_R5: assert property (@(posedge clk) disable iff (por_det)
    (wdt_to && sleep_st && !ext_rst && !(brown_det && brown_en) && !chip_rst)
      |=> (!chip_rst && wake && !flag_timeout));

  assert_wake_one_cycle_R5: assert property (@(posedge clk) disable iff (por_det)
    (wake && !wdt_to) |=> !wake);

  assert_brown_masked_R6: assert property (@(posedge clk) disable iff (por_det)
    (brown_det && !brown_en && !ext_rst && !wdt_to && !chip_rst) |=> !chip_rst);

  assert_sleep_clears_pd_R7: assert property (@(posedge clk) disable iff (por_det)
    (sleep_entry && !(brown_det && brown_en)) |=> !flag_pwrdn);

  assert_release_gated_R8: assert property (@(posedge clk) disable iff (por_det)
    $fell(chip_rst) |-> (pwrup_ok && oscst_ok));

  assert_cascade_order_R8: assert property (@(posedge clk) disable iff (por_det)
    oscst_adv |-> pwrup_ok);
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk(clk), .por_det(por_det), .brown_det(brown_det), .brown_en(brown_en),
  .ext_rst(ext_rst), .wdt_to(wdt_to), .sleep_st(sleep_st),
  .chip_rst(chip_rst), .wake(wake), .flag_timeout(flag_timeout),
  .flag_pwrdn(flag_pwrdn), .pwrup_ok(pwrup_ok), .oscst_ok(oscst_ok),
  .oscst_adv(oscst_adv), .sleep_entry(sleep_entry)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;   // 8 slow ticks
  localparam int OW = 2;   // 4 external ticks

  typedef struct packed {
    logic       sleep, ext, wdt, brown, brown_en;
    logic       e_rst, e_to, e_pd, e_wake;
    logic [2:0] e_cause;
  } vec_t;

  // Sequence-dependent: power-down flag history carries across rows.
  localparam vec_t VEC [11] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 3'd1}, // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 3'd3}, // R4
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 3'd4}, // R5 R7
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 3'd2}, // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0, 3'd5}, // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b0, 3'd5}, // R6 masked
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0, 3'd5}, // R11
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 3'd1}, // R11
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 3'd2}, // R11
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 3'd3}, // R4
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 3'd4}  // R5 R6
  };

  logic clk = 1'b0;
  logic por_det = 1'b1, brown_det = 1'b0, brown_en = 1'b0, ext_rst = 1'b0;
  logic wdt_to = 1'b0, sleep_st = 1'b0, pwrup_en = 1'b1, oscst_en = 1'b1;
  logic lfosc_tick = 1'b0, xosc_tick = 1'b0;
  logic chip_rst, wake, flag_timeout, flag_pwrdn;
  logic [2:0] cause;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_ctrl #(.PWRUP_W(PW), .OSCST_W(OW)) u_dut (
    .clk(clk), .por_det(por_det), .brown_det(brown_det), .brown_en(brown_en),
    .ext_rst(ext_rst), .wdt_to(wdt_to), .sleep_st(sleep_st),
    .pwrup_en(pwrup_en), .oscst_en(oscst_en), .lfosc_tick(lfosc_tick),
    .xosc_tick(xosc_tick), .chip_rst(chip_rst), .wake(wake),
    .flag_timeout(flag_timeout), .flag_pwrdn(flag_pwrdn), .cause(cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lf_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      lfosc_tick = 1'b1; repeat (3) @(negedge clk);
      lfosc_tick = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic xo_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      xosc_tick = 1'b1; repeat (3) @(negedge clk);
      xosc_tick = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic ext_pulse();
    ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: power-on state
    repeat (3) @(negedge clk);
    check("R1 rst", chip_rst, 1);
    check("R1 to", flag_timeout, 1);
    check("R1 pd", flag_pwrdn, 1);
    check("R1 cause", cause, 0);
    por_det = 1'b0;
    @(negedge clk);
    // R8 / R12: ordered release; early external ticks ignored
    lf_pulse(7);
    xo_pulse(4);
    check("R8 hold before pwrup done", chip_rst, 1);
    lf_pulse(1);
    check("R8 hold after pwrup only", chip_rst, 1);
    check("R1 cause held", cause, 0);
    xo_pulse(3);
    check("R8 hold 3 of 4 osc", chip_rst, 1);
    xo_pulse(1);
    check("R8 R12 released", chip_rst, 0);

    // Table walk, both delays disabled
    pwrup_en = 1'b0; oscst_en = 1'b0;
    foreach (VEC[i]) begin
      sleep_st = VEC[i].sleep;
      repeat (3) @(negedge clk);
      ext_rst = VEC[i].ext; wdt_to = VEC[i].wdt;
      brown_det = VEC[i].brown; brown_en = VEC[i].brown_en;
      @(negedge clk);
      ext_rst = 1'b0; wdt_to = 1'b0; brown_det = 1'b0; brown_en = 1'b0;
      check($sformatf("R2-6 row%0d rst", i), chip_rst, VEC[i].e_rst);
      check($sformatf("R11 row%0d to", i), flag_timeout, VEC[i].e_to);
      check($sformatf("R7 row%0d pd", i), flag_pwrdn, VEC[i].e_pd);
      check($sformatf("R5 row%0d wake", i), wake, VEC[i].e_wake);
      check($sformatf("R3 row%0d cause", i), cause, VEC[i].e_cause);
      @(negedge clk);
      check($sformatf("R9 R5 row%0d one-cycle", i), {chip_rst, wake}, 0);
      repeat (2) @(negedge clk);
    end
    sleep_st = 1'b0;
    repeat (3) @(negedge clk);

    // R10: restart during countdown (power-up only)
    pwrup_en = 1'b1; oscst_en = 1'b0;
    ext_pulse();
    lf_pulse(6);
    ext_pulse();
    lf_pulse(6);
    check("R10 restarted count holds", chip_rst, 1);
    lf_pulse(2);
    check("R10 R9 released after 8", chip_rst, 0);

    // R9: oscillator delay only
    pwrup_en = 1'b0; oscst_en = 1'b1;
    ext_pulse();
    xo_pulse(3);
    check("R9 osc-only hold", chip_rst, 1);
    xo_pulse(1);
    check("R9 osc-only release", chip_rst, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule